// File: doc/BRIEF.md
# Quad Segmented DAC Input Decoder

This block is the digital front end for four 10-bit current-steering converter channels. Each channel's code is registered in a first rank, then split. The four upper bits become a 15-line thermometer vector that steers equal-weight current segments. The six lower bits go through unchanged as enables for binary-weighted sources. A second rank re-times both vectors, and its outputs drive the analog switch array directly.

Power is handled in two layers. A per-channel sleep bit blanks that channel's switch enables and drops its enable flag, while the shared reference stays alive for the other channels. A global off input blanks every channel, whatever the sleep bits say, and also drops the reference-alive flag. The first rank keeps capturing codes during sleep or off, so a channel resumes with the latest latched code as soon as it is released.

Top module: `quad_seg_dac_dec`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, both ranks clear. On the following edges all `seg_on`, `bin_on`, `chan_en` and `ref_alive` bits are 0.
- R2: An active channel's outputs reflect the code present at `code_in` two rising clock edges earlier.
- R3: For channel c with upper field k = code[9:6], bit c*15+i of `seg_on` is 1 exactly when i < k, for i = 0..14.
- R4: For an active channel c, `bin_on[c*6 +: 6]` equals code[5:0].
- R5: For an active channel, the count of set `seg_on` lines times 64, plus the value of `bin_on`, equals the 10-bit code.
- R6: Channel c takes its code from `code_in[c*10 +: 10]` only. A change on one channel's field leaves the other channels' outputs unchanged.
- R7: When `chan_sleep[c]` is sampled high, then on the next edge channel c's `seg_on` and `bin_on` are all 0 and `chan_en[c]` is 0. Other channels are unaffected, and `ref_alive` stays 1 as long as `all_off` is low.
- R8: When `all_off` is sampled high, then on the next edge every channel is blanked and `ref_alive` is 0, regardless of `chan_sleep`.
- R9: When a channel's sleep or off condition is released, it shows its currently latched code on the next edge, with no new input.
- R10: `chan_en[c]` is 1 one edge after both `chan_sleep[c]` and `all_off` are sampled low outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 40 | Four 10-bit codes, channel c at bits c*10 +: 10 |
| chan_sleep | input | 4 | Per-channel power-save, bit c for channel c |
| all_off | input | 1 | Global power-down, overrides `chan_sleep` |
| seg_on | output | 60 | Thermometer segment enables, channel c at bits c*15 +: 15 |
| bin_on | output | 24 | Binary source enables, channel c at bits c*6 +: 6 |
| chan_en | output | 4 | Channel enabled flags |
| ref_alive | output | 1 | Shared reference running flag |

## Verification
Code movement through the two ranks can coincide with a power transition. A code change that is still in the pipe can reach the second rank on the same edge that sleep or off is released. The bench provokes this by asserting sleep and off while it changes the codes, then releasing them without touching the inputs again. It expects the output, one edge after release, to carry the newest latched code rather than a stale or blank value. A second case asserts global off while the sleep bits are mixed, and judges that every channel is blanked and the reference flag drops, with no dependence on the sleep pattern.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned QD_CHANNELS   = 4;
  localparam int unsigned QD_CODE_W     = 10;
  localparam int unsigned QD_UNARY_BITS = 4;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_OFF    = 2'd2
  } pwr_state_t;

  function automatic pwr_state_t pwr_of(input logic sleep, input logic off);
    if (off)        return PWR_OFF;
    else if (sleep) return PWR_SLEEP;
    else            return PWR_ACTIVE;
  endfunction
endpackage

// File: rtl/qdac_latch1.sv
module qdac_latch1 #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // first rank keeps sampling even while the channel is powered down
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/qdac_therm_dec.sv
module qdac_therm_dec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned LINES = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  val,
  output logic [LINES-1:0] therm
);
  // line i is on when the field value exceeds i
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign therm[i] = (val > IN_W'(i));
  end
endmodule

// File: rtl/qdac_latch2.sv
module qdac_latch2
  import qdac_pkg::*;
#(
  parameter int unsigned SEG_W = 15,
  parameter int unsigned BIN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  pwr_state_t       pwr,
  input  logic [SEG_W-1:0] seg_d,
  input  logic [BIN_W-1:0] bin_d,
  output logic [SEG_W-1:0] seg_q,
  output logic [BIN_W-1:0] bin_q,
  output logic             en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      bin_q <= '0;
      en_q  <= 1'b0;
    end else if (pwr == PWR_ACTIVE) begin
      seg_q <= seg_d;
      bin_q <= bin_d;
      en_q  <= 1'b1;
    end else begin
      seg_q <= '0;
      bin_q <= '0;
      en_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_seg_dac_dec.sv
module quad_seg_dac_dec
  import qdac_pkg::*;
#(
  parameter int unsigned CHANNELS   = QD_CHANNELS,
  parameter int unsigned CODE_W     = QD_CODE_W,
  parameter int unsigned UNARY_BITS = QD_UNARY_BITS,
  localparam int unsigned BIN_W     = CODE_W - UNARY_BITS,
  localparam int unsigned SEG_W     = (1 << UNARY_BITS) - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CHANNELS*CODE_W-1:0] code_in,
  input  logic [CHANNELS-1:0]        chan_sleep,
  input  logic                      all_off,
  output logic [CHANNELS*SEG_W-1:0]  seg_on,
  output logic [CHANNELS*BIN_W-1:0]  bin_on,
  output logic [CHANNELS-1:0]        chan_en,
  output logic                      ref_alive
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [CODE_W-1:0] held;
    logic [SEG_W-1:0]  therm;
    pwr_state_t        pwr;

    qdac_latch1 #(.W(CODE_W)) u_l1 (
      .clk (clk),
      .rst (rst),
      .d   (code_in[c*CODE_W +: CODE_W]),
      .q   (held)
    );

    qdac_therm_dec #(.IN_W(UNARY_BITS)) u_dec (
      .val   (held[CODE_W-1 -: UNARY_BITS]),
      .therm (therm)
    );

    assign pwr = pwr_of(chan_sleep[c], all_off);

    qdac_latch2 #(.SEG_W(SEG_W), .BIN_W(BIN_W)) u_l2 (
      .clk   (clk),
      .rst   (rst),
      .pwr   (pwr),
      .seg_d (therm),
      .bin_d (held[BIN_W-1:0]),
      .seg_q (seg_on[c*SEG_W +: SEG_W]),
      .bin_q (bin_on[c*BIN_W +: BIN_W]),
      .en_q  (chan_en[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ref_alive <= 1'b0;
    else     ref_alive <= ~all_off;
  end
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
  parameter int unsigned CHANNELS   = 4,
  parameter int unsigned CODE_W     = 10,
  parameter int unsigned UNARY_BITS = 4,
  localparam int unsigned BIN_W     = CODE_W - UNARY_BITS,
  localparam int unsigned SEG_W     = (1 << UNARY_BITS) - 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [CHANNELS*CODE_W-1:0] code_in,
  input logic [CHANNELS-1:0]        chan_sleep,
  input logic                       all_off,
  input logic [CHANNELS*SEG_W-1:0]  seg_on,
  input logic [CHANNELS*BIN_W-1:0]  bin_on,
  input logic [CHANNELS-1:0]        chan_en,
  input logic                       ref_alive
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8
  all_off_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $past(all_off)) |-> (chan_en == '0 && !ref_alive && seg_on == '0 && bin_on == '0));

  // R7
  ref_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && !$past(all_off)) |-> ref_alive);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_c
    // R7
    sleep_blank_chk: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd1 && $past(chan_sleep[c])) |->
        (!chan_en[c] && seg_on[c*SEG_W +: SEG_W] == '0 && bin_on[c*BIN_W +: BIN_W] == '0));

    // R3
    therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
      ((seg_on[c*SEG_W +: SEG_W] & (seg_on[c*SEG_W +: SEG_W] + SEG_W'(1))) == '0));

    // R10
    enable_chk: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd1 && !$past(chan_sleep[c]) && !$past(all_off)) |-> chan_en[c]);

    // R5
    weight_chk: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd2 && chan_en[c]) |->
        ($countones(seg_on[c*SEG_W +: SEG_W]) * (1 << BIN_W) + int'(bin_on[c*BIN_W +: BIN_W])
          == int'($past(code_in[c*CODE_W +: CODE_W], 2))));
  end
endmodule

bind quad_seg_dac_dec qdac_chk #(
  .CHANNELS(CHANNELS), .CODE_W(CODE_W), .UNARY_BITS(UNARY_BITS)
) u_chk (
  .clk(clk), .rst(rst), .code_in(code_in), .chan_sleep(chan_sleep),
  .all_off(all_off), .seg_on(seg_on), .bin_on(bin_on),
  .chan_en(chan_en), .ref_alive(ref_alive)
);

// File: tb/sim_quad_seg_dac_dec.sv
`timescale 1ns/1ps
module sim_quad_seg_dac_dec;
  localparam int CH = 4;
  localparam int CW = 10;
  localparam int SW = 15;
  localparam int BW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CH*CW-1:0]  code_in = '0;
  logic [CH-1:0]     chan_sleep = '0;
  logic              all_off = 1'b0;
  logic [CH*SW-1:0]  seg_on;
  logic [CH*BW-1:0]  bin_on;
  logic [CH-1:0]     chan_en;
  logic              ref_alive;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  quad_seg_dac_dec u0 (
    .clk(clk), .rst(rst), .code_in(code_in), .chan_sleep(chan_sleep),
    .all_off(all_off), .seg_on(seg_on), .bin_on(bin_on),
    .chan_en(chan_en), .ref_alive(ref_alive)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(input int c, input logic [CW-1:0] v);
    code_in[c*CW +: CW] = v;
  endtask

  task automatic chk(input int c, input logic [CW-1:0] code, input bit on, input string req);
    logic [SW-1:0] es;
    logic [BW-1:0] eb;
    es = '0;
    eb = '0;
    if (on) begin
      for (int i = 0; i < SW; i++) if (i < int'(code[9:6])) es[i] = 1'b1;
      eb = code[5:0];
    end
    checks++;
    if (seg_on[c*SW +: SW] !== es || bin_on[c*BW +: BW] !== eb || chan_en[c] !== on) begin
      errs++;
      $display("FAIL %s ch%0d: seg=%h bin=%h en=%b expected seg=%h bin=%h en=%b",
               req, c, seg_on[c*SW +: SW], bin_on[c*BW +: BW], chan_en[c], es, eb, on);
    end
  endtask

  task automatic chk_ref(input logic exp, input string req);
    checks++;
    if (ref_alive !== exp) begin
      errs++;
      $display("FAIL %s ref_alive: got %b expected %b", req, ref_alive, exp);
    end
  endtask

  task automatic chk_weight(input int c, input logic [CW-1:0] code);
    int w;
    w = $countones(seg_on[c*SW +: SW]) * 64 + int'(bin_on[c*BW +: BW]);
    checks++;
    if (w != int'(code)) begin
      errs++;
      $display("FAIL R5 ch%0d weight: got %0d expected %0d", c, w, code);
    end
  endtask

  // R1: reset clears all outputs even with live codes on the inputs
  task automatic t_reset();
    rst = 1'b1;
    for (int c = 0; c < CH; c++) put(c, 10'h3FF - 10'(c));
    tick(); tick();
    for (int c = 0; c < CH; c++) chk(c, 10'd0, 1'b0, "R1");
    chk_ref(1'b0, "R1");
    rst = 1'b0;
    tick(); tick();
    // R10: enables come up once out of reset
    for (int c = 0; c < CH; c++) chk(c, 10'h3FF - 10'(c), 1'b1, "R10");
    chk_ref(1'b1, "R10");
  endtask

  // R2: two-edge latency
  task automatic t_latency();
    for (int c = 0; c < CH; c++) put(c, 10'd100);
    tick(); tick();
    for (int c = 0; c < CH; c++) put(c, 10'd600 + 10'(c));
    tick();
    for (int c = 0; c < CH; c++) chk(c, 10'd100, 1'b1, "R2 one edge");
    tick();
    for (int c = 0; c < CH; c++) chk(c, 10'd600 + 10'(c), 1'b1, "R2 two edges");
  endtask

  // R3 R4 R5 R6: every code on every channel, channels offset from each other
  task automatic t_sweep();
    for (int v = 0; v < 1024; v++) begin
      for (int c = 0; c < CH; c++) put(c, 10'((v + c * 257) % 1024));
      tick(); tick();
      for (int c = 0; c < CH; c++) begin
        chk(c, 10'((v + c * 257) % 1024), 1'b1, "R3/R4/R6");
        chk_weight(c, 10'((v + c * 257) % 1024));
      end
    end
  endtask

  // R6: one channel changes, others hold
  task automatic t_isolate();
    for (int c = 0; c < CH; c++) put(c, 10'd321);
    tick(); tick();
    put(2, 10'd1000);
    tick(); tick();
    chk(0, 10'd321, 1'b1, "R6");
    chk(1, 10'd321, 1'b1, "R6");
    chk(2, 10'd1000, 1'b1, "R6");
    chk(3, 10'd321, 1'b1, "R6");
  endtask

  // R7 then R9: sleep two channels, change codes while asleep, release
  task automatic t_sleep_wake();
    for (int c = 0; c < CH; c++) put(c, 10'd777);
    tick(); tick();
    chan_sleep = 4'b0101;
    tick();
    chk(0, 10'd0, 1'b0, "R7");
    chk(1, 10'd777, 1'b1, "R7");
    chk(2, 10'd0, 1'b0, "R7");
    chk(3, 10'd777, 1'b1, "R7");
    chk_ref(1'b1, "R7");
    put(0, 10'd63);
    put(2, 10'd64);
    tick(); tick();
    chk(0, 10'd0, 1'b0, "R7 held");
    chk(2, 10'd0, 1'b0, "R7 held");
    chan_sleep = 4'b0000;
    tick();
    chk(0, 10'd63, 1'b1, "R9");
    chk(2, 10'd64, 1'b1, "R9");
  endtask

  // R8 then R9: global off overrides mixed sleep bits; new code lands at release
  task automatic t_all_off();
    for (int c = 0; c < CH; c++) put(c, 10'd512);
    tick(); tick();
    chan_sleep = 4'b0011;
    all_off = 1'b1;
    for (int c = 0; c < CH; c++) put(c, 10'd900 - 10'(c));
    tick();
    for (int c = 0; c < CH; c++) chk(c, 10'd0, 1'b0, "R8");
    chk_ref(1'b0, "R8");
    chan_sleep = 4'b0000;
    tick();
    for (int c = 0; c < CH; c++) chk(c, 10'd0, 1'b0, "R8 no sleep");
    chk_ref(1'b0, "R8 no sleep");
    all_off = 1'b0;
    tick();
    for (int c = 0; c < CH; c++) chk(c, 10'd900 - 10'(c), 1'b1, "R9");
    chk_ref(1'b1, "R9");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    t_latency();
    t_sweep();
    t_isolate();
    t_sleep_wake();
    t_all_off();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule